// File: doc/BRIEF.md
# Multi-Channel ADC Scan Controller with Window Comparator

This block sequences an external analog-to-digital converter over a software-selected set of input channels. Software programs a channel-select mask, a lower and an upper comparison bound, and a control word, all through a plain 32-bit register strobe interface. Setting the start bit launches a scan. The scan asks the converter for one sample per selected channel, in ascending channel order, over a request/done handshake.

Each returned sample is tested against the programmed window. Depending on the comparator mode, a sample that falls outside the window, or one that falls inside it, raises a comparator flag. Completing a pass over the selected channels raises a scan flag. Each flag drives an interrupt line when its enable bit is set.

In one-shot mode the scan runs a single pass and the start bit then drops by itself. In free-run mode the scan repeats until software writes the start bit low.

Top module: `adc_scan_ctl`

## Requirements
- R1: Registers sit at byte addresses 0x0 (control), 0x4 (channel mask, bit n selects channel n), 0x8 (lower bound) and 0xC (upper bound). Mask and bounds read back zero-extended. In the control word, bit 0 is start, bit 1 is scan mode (1 = free-run), bit 2 is scan interrupt enable, bit 3 is the scan flag, bit 4 is comparator mode, bit 5 is comparator interrupt enable, bit 6 is the comparator flag and bit 7 is busy. Control bits 31..8 read 0.
- R2: After reset every register reads 0 and no conversion is requested.
- R3: A control write with bit 0 = 1 while idle and with a nonzero mask asserts conv_req_o in the next cycle, with the lowest selected channel. While the scan runs, start and busy both read 1. With an empty mask the same write does nothing and start reads 0.
- R4: Every request is a single-cycle pulse. After each conv_done_i, the next selected channel above the current one is requested in the following cycle.
- R5: In one-shot mode, the cycle after the done of the highest selected channel, start and busy read 0 and the scan flag is set.
- R6: In free-run mode, after the highest selected channel completes, the scan flag is set and the lowest selected channel is requested in the next cycle.
- R7: In free-run mode, a control write with bit 0 = 0 ends the scan by the next cycle, and a done arriving in that same cycle sets no flag. In one-shot mode such a write does not stop the scan.
- R8: With comparator mode 0, a result below the lower bound or above the upper bound sets the comparator flag. With mode 1, a result with lower ≤ result ≤ upper sets it.
- R9: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a new event and a clear land in the same cycle, the flag ends up set.
- R10: scan_irq_o equals scan flag AND scan enable, and cmp_irq_o equals comparator flag AND comparator enable.
- R11: A start write during a running scan does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address for read and write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| conv_req_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | CH_W | Channel for the current conversion |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | DATA_W | Converter result |
| scan_irq_o | output | 1 | Scan-complete interrupt |
| cmp_irq_o | output | 1 | Window comparator interrupt |

## Verification
A wrong sequencer state shows up within one cycle at the ports. It appears as a missing or doubled conv_req_o pulse, a wrong conv_chan_o, or busy and start reading back a value the scan position does not justify. A wrong channel pick or a wrong pass-end decision surfaces at the request that follows the offending done. A wrong flag or comparator decision reads back in the control word on the cycle after the event, and the interrupt pins show it at the same time. The bench checks every port against a behavioural model on every cycle, so the first cycle of divergence is reported.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_WAIT} seq_state_e;

  localparam int unsigned CTL_START = 0;
  localparam int unsigned CTL_SMODE = 1;
  localparam int unsigned CTL_SIE   = 2;
  localparam int unsigned CTL_SFLAG = 3;
  localparam int unsigned CTL_CMODE = 4;
  localparam int unsigned CTL_CIE   = 5;
  localparam int unsigned CTL_CFLAG = 6;
  localparam int unsigned CTL_BUSY  = 7;

  localparam int unsigned OFS_CTL  = 0;
  localparam int unsigned OFS_MASK = 4;
  localparam int unsigned OFS_LO   = 8;
  localparam int unsigned OFS_HI   = 12;
endpackage

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 8,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic                busy_i,
  input  logic                scan_evt_i,
  input  logic                cmp_evt_i,
  output logic [NUM_CHAN-1:0] mask_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic [DATA_W-1:0]   hi_o,
  output logic                smode_o,
  output logic                cmode_o,
  output logic                start_wr_o,
  output logic                stop_wr_o,
  output logic                scan_irq_o,
  output logic                cmp_irq_o
);
  logic sel_ctl, sel_mask, sel_lo, sel_hi, ctl_we;
  logic smode_q, sie_q, cmode_q, cie_q, scan_flag_q, cmp_flag_q;
  logic [NUM_CHAN-1:0] mask_q;
  logic [DATA_W-1:0]   lo_q, hi_q;
  logic [31:0]         ctl_rd;

  assign sel_ctl  = (addr_i == ADDR_W'(OFS_CTL));
  assign sel_mask = (addr_i == ADDR_W'(OFS_MASK));
  assign sel_lo   = (addr_i == ADDR_W'(OFS_LO));
  assign sel_hi   = (addr_i == ADDR_W'(OFS_HI));
  assign ctl_we   = we_i & sel_ctl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smode_q <= 1'b0;
      sie_q   <= 1'b0;
      cmode_q <= 1'b0;
      cie_q   <= 1'b0;
      mask_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (ctl_we) begin
        smode_q <= wdata_i[CTL_SMODE];
        sie_q   <= wdata_i[CTL_SIE];
        cmode_q <= wdata_i[CTL_CMODE];
        cie_q   <= wdata_i[CTL_CIE];
      end
      if (we_i && sel_mask) mask_q <= wdata_i[NUM_CHAN-1:0];
      if (we_i && sel_lo)   lo_q   <= wdata_i[DATA_W-1:0];
      if (we_i && sel_hi)   hi_q   <= wdata_i[DATA_W-1:0];
    end
  end

  // new event outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_flag_q <= 1'b0;
      cmp_flag_q  <= 1'b0;
    end else begin
      scan_flag_q <= scan_evt_i | (scan_flag_q & ~(ctl_we & wdata_i[CTL_SFLAG]));
      cmp_flag_q  <= cmp_evt_i  | (cmp_flag_q  & ~(ctl_we & wdata_i[CTL_CFLAG]));
    end
  end

  always_comb begin
    ctl_rd            = '0;
    ctl_rd[CTL_START] = busy_i;
    ctl_rd[CTL_SMODE] = smode_q;
    ctl_rd[CTL_SIE]   = sie_q;
    ctl_rd[CTL_SFLAG] = scan_flag_q;
    ctl_rd[CTL_CMODE] = cmode_q;
    ctl_rd[CTL_CIE]   = cie_q;
    ctl_rd[CTL_CFLAG] = cmp_flag_q;
    ctl_rd[CTL_BUSY]  = busy_i;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctl)  rdata_o = ctl_rd;
    if (sel_mask) rdata_o = 32'(mask_q);
    if (sel_lo)   rdata_o = 32'(lo_q);
    if (sel_hi)   rdata_o = 32'(hi_q);
  end

  assign mask_o     = mask_q;
  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign smode_o    = smode_q;
  assign cmode_o    = cmode_q;
  assign start_wr_o = ctl_we & wdata_i[CTL_START];
  assign stop_wr_o  = ctl_we & ~wdata_i[CTL_START] & smode_q;
  assign scan_irq_o = scan_flag_q & sie_q;
  assign cmp_irq_o  = cmp_flag_q & cie_q;

  // R9
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_evt_i |=> scan_flag_q);
  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we && wdata_i[CTL_CFLAG] && !cmp_evt_i) |=> !cmp_flag_q);
  // R9
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_flag_q && !(ctl_we && wdata_i[CTL_CFLAG])) |=> cmp_flag_q);
endmodule

// File: rtl/adc_win_cmp.sv
module adc_win_cmp #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              vld_i,
  input  logic              inside_mode_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              evt_o
);
  logic in_win;
  assign in_win = (data_i >= lo_i) && (data_i <= hi_i);
  assign evt_o  = vld_i & (inside_mode_i ? in_win : ~in_win);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 8,
  localparam int unsigned CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                smode_i,
  input  logic [NUM_CHAN-1:0] mask_i,
  input  logic                done_i,
  output logic                conv_req_o,
  output logic [CH_W-1:0]     conv_chan_o,
  output logic                busy_o,
  output logic                res_vld_o,
  output logic                scan_evt_o
);
  seq_state_e state_q, state_d;
  logic [CH_W-1:0] chan_q, chan_d, low_ch, nxt_ch;
  logic low_hit, nxt_hit, any_sel, accept;

  assign any_sel = |mask_i;

  always_comb begin
    low_hit = 1'b0;
    low_ch  = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        low_hit = 1'b1;
        low_ch  = CH_W'(i);
      end
    end
  end

  always_comb begin
    nxt_hit = 1'b0;
    nxt_ch  = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (mask_i[i] && (i > int'(chan_q))) begin
        nxt_hit = 1'b1;
        nxt_ch  = CH_W'(i);
      end
    end
  end

  assign accept = (state_q == SEQ_WAIT) && done_i && !stop_i;

  always_comb begin
    state_d    = state_q;
    chan_d     = chan_q;
    scan_evt_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (start_i && low_hit) begin
        state_d = SEQ_REQ;
        chan_d  = low_ch;
      end
      SEQ_REQ:  state_d = stop_i ? SEQ_IDLE : SEQ_WAIT;
      SEQ_WAIT: begin
        if (stop_i) begin
          state_d = SEQ_IDLE;
        end else if (done_i) begin
          if (nxt_hit) begin
            state_d = SEQ_REQ;
            chan_d  = nxt_ch;
          end else begin
            scan_evt_o = 1'b1;
            if (smode_i && any_sel) begin
              state_d = SEQ_REQ;
              chan_d  = low_ch;
            end else begin
              state_d = SEQ_IDLE;
            end
          end
        end
      end
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      chan_q  <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
    end
  end

  assign conv_req_o  = (state_q == SEQ_REQ);
  assign conv_chan_o = chan_q;
  assign busy_o      = (state_q != SEQ_IDLE);
  assign res_vld_o   = accept;

  // R4
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);
  // R5
  oneshot_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !nxt_hit && !smode_i) |=> !busy_o);
  // R7
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i) |=> !busy_o);
endmodule

// File: rtl/adc_scan_ctl.sv
module adc_scan_ctl #(
  parameter int unsigned NUM_CHAN = 8,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned ADDR_W   = 4,
  localparam int unsigned CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              conv_req_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_data_i,
  output logic              scan_irq_o,
  output logic              cmp_irq_o
);
  logic [NUM_CHAN-1:0] mask;
  logic [DATA_W-1:0]   lo, hi;
  logic smode, cmode, start_wr, stop_wr, busy, res_vld, scan_evt, cmp_evt;

  adc_scan_regs #(.NUM_CHAN(NUM_CHAN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .busy_i     (busy),
    .scan_evt_i (scan_evt),
    .cmp_evt_i  (cmp_evt),
    .mask_o     (mask),
    .lo_o       (lo),
    .hi_o       (hi),
    .smode_o    (smode),
    .cmode_o    (cmode),
    .start_wr_o (start_wr),
    .stop_wr_o  (stop_wr),
    .scan_irq_o,
    .cmp_irq_o
  );

  adc_scan_seq #(.NUM_CHAN(NUM_CHAN)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start_wr),
    .stop_i     (stop_wr),
    .smode_i    (smode),
    .mask_i     (mask),
    .done_i     (conv_done_i),
    .conv_req_o,
    .conv_chan_o,
    .busy_o     (busy),
    .res_vld_o  (res_vld),
    .scan_evt_o (scan_evt)
  );

  adc_win_cmp #(.DATA_W(DATA_W)) u_cmp (
    .vld_i         (res_vld),
    .inside_mode_i (cmode),
    .data_i        (conv_data_i),
    .lo_i          (lo),
    .hi_i          (hi),
    .evt_o         (cmp_evt)
  );
endmodule

// File: tb/sim_adc_scan_ctl.sv
module sim_adc_scan_ctl;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int AW  = 4;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req;
  logic [CW-1:0] chan;
  logic done = 1'b0;
  logic [DW-1:0] cdata = '0;
  logic sirq, cirq;

  int n_chk = 0, n_fail = 0;
  int req_cnt = 0;
  int val [NCH];

  always #5 clk = ~clk;

  adc_scan_ctl #(.NUM_CHAN(NCH), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .conv_req_o(req),
    .conv_chan_o(chan), .conv_done_i(done), .conv_data_i(cdata),
    .scan_irq_o(sirq), .cmp_irq_o(cirq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_state, m_chan, m_mask, m_lo, m_hi;
  bit m_smode, m_sie, m_cm, m_cie, m_sf, m_cf;

  function automatic int lowest(input int msk);
    for (int i = 0; i < NCH; i++) if (msk[i]) return i;
    return -1;
  endfunction

  function automatic int above(input int msk, input int c);
    for (int i = c + 1; i < NCH; i++) if (msk[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    logic [31:0] r = '0;
    if (a == 0) begin
      r[0] = (m_state != 0); r[1] = m_smode; r[2] = m_sie; r[3] = m_sf;
      r[4] = m_cm; r[5] = m_cie; r[6] = m_cf; r[7] = (m_state != 0);
    end else if (a == 4) r = m_mask;
    else if (a == 8) r = m_lo;
    else if (a == 12) r = m_hi;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_chan = 0; m_mask = 0; m_lo = 0; m_hi = 0;
      m_smode = 0; m_sie = 0; m_cm = 0; m_cie = 0; m_sf = 0; m_cf = 0;
    end else begin
      bit wctl, stp, sev, cev, inwin;
      int ns, nch, nx;
      wctl = we && addr == 0;
      stp  = wctl && !wdata[0] && m_smode;
      sev = 0; cev = 0; ns = m_state; nch = m_chan;
      if (m_state == 0) begin
        if (wctl && wdata[0] && m_mask != 0) begin ns = 1; nch = lowest(m_mask); end
      end else if (m_state == 1) begin
        ns = stp ? 0 : 2;
      end else begin
        if (stp) ns = 0;
        else if (done) begin
          inwin = (int'(cdata) >= m_lo) && (int'(cdata) <= m_hi);
          cev = m_cm ? inwin : !inwin;
          nx = above(m_mask, m_chan);
          if (nx >= 0) begin ns = 1; nch = nx; end
          else begin
            sev = 1;
            if (m_smode && m_mask != 0) begin ns = 1; nch = lowest(m_mask); end
            else ns = 0;
          end
        end
      end
      m_sf = sev || (m_sf && !(wctl && wdata[3]));
      m_cf = cev || (m_cf && !(wctl && wdata[6]));
      if (wctl) begin
        m_smode = wdata[1]; m_sie = wdata[2]; m_cm = wdata[4]; m_cie = wdata[5];
      end
      if (we && addr == 4) m_mask = wdata[NCH-1:0];
      if (we && addr == 8) m_lo = wdata[DW-1:0];
      if (we && addr == 12) m_hi = wdata[DW-1:0];
      m_state = ns; m_chan = nch;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(rdata, exp_rd(addr), "R1 readback");
      chk(32'(req), 32'(m_state == 1), "R4 request");
      if (m_state == 1) chk(32'(chan), 32'(m_chan), "R4 channel");
      chk(32'(sirq), 32'(m_sf & m_sie), "R10 scan irq");
      chk(32'(cirq), 32'(m_cf & m_cie), "R10 cmp irq");
    end
  end

  // converter responder
  int rsp_cnt = 0, rsp_ch = 0;
  always @(negedge clk) begin
    done = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        done = 1'b1;
        cdata = DW'(val[rsp_ch]);
      end
    end
    if (rst_n && req) begin
      req_cnt++;
      rsp_ch = int'(chan);
      rsp_cnt = 1 + (rsp_ch % 3);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] msk, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = AW'(a);
    #2;
    chk(rdata & msk, exp, tag);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000 && m_state != 0; k++) @(negedge clk);
  endtask

  task automatic single(input int v, input bit cm, input bit exp_flag);
    val[3] = v;
    wr(0, 32'h48);                      // clear both flags
    wr(0, 32'(cm) << 4 | 32'h1);
    wait_idle();
    // R8 comparator decision, R5 flag and start state after one shot
    rd_chk(0, 32'hFFFF_FFFF, (32'(cm) << 4) | 32'h8 | (32'(exp_flag) << 6), "R8 window");
  endtask

  initial begin
    int base;
    for (int i = 0; i < NCH; i++) val[i] = 150;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd_chk(0, 32'hFFFF_FFFF, 0, "R2 ctl");
    rd_chk(4, 32'hFFFF_FFFF, 0, "R2 mask");
    rd_chk(8, 32'hFFFF_FFFF, 0, "R2 lo");
    rd_chk(12, 32'hFFFF_FFFF, 0, "R2 hi");
    chk(32'(req), 0, "R2 no request");

    // R3 empty mask
    base = req_cnt;
    wr(0, 32'h1);
    rd_chk(0, 32'h81, 0, "R3 empty mask start");
    repeat (4) @(negedge clk);
    chk(32'(req_cnt - base), 0, "R3 no request");

    // R1 program mask/bounds; upper write bits ignored
    wr(4, 32'hFFFF_FFA5);
    rd_chk(4, 32'hFFFF_FFFF, 32'hA5, "R1 mask");
    wr(8, 100);
    wr(12, 200);
    rd_chk(12, 32'hFFFF_FFFF, 200, "R1 hi");
    wr(0, 32'hFFFF_FF00 | 32'h24);
    rd_chk(0, 32'hFFFF_FF00, 0, "R1 upper bits");

    // one-shot scan: ch0 outside window
    val[0] = 50;
    base = req_cnt;
    @(negedge clk); we = 1'b1; addr = 0; wdata = 32'h25;
    @(negedge clk); we = 1'b0;
    #1;
    chk(32'(req), 1, "R3 request after start");
    chk(32'(chan), 0, "R3 lowest channel");
    rd_chk(0, 32'h81, 32'h81, "R3 start busy read 1");
    repeat (6) @(negedge clk);
    wr(0, 32'h25);                         // R11 restart attempt
    wr(0, 32'h24);                         // R7 stop ignored in one-shot
    chk(32'(m_state != 0), 1, "R7 one-shot keeps running");
    wait_idle();
    chk(32'(req_cnt - base), 4, "R11 R4 four requests");
    rd_chk(0, 32'hFF, 32'h6C, "R5 one-shot end");

    // R9 write 0 keeps flags; R10 enables gate irq
    wr(0, 32'h0);
    rd_chk(0, 32'h48, 32'h48, "R9 write zero");
    chk(32'(sirq | cirq), 0, "R10 disabled");
    wr(0, 32'h24);
    #1;
    chk(32'({sirq, cirq}), 32'h3, "R10 enabled");
    wr(0, 32'h2C);
    rd_chk(0, 32'h48, 32'h40, "R9 clear scan flag");

    // R8 window boundaries, single channel 3
    wr(4, 32'h08);
    single(100, 1, 1);
    single(200, 1, 1);
    single(99, 1, 0);
    single(201, 1, 0);
    single(99, 0, 1);
    single(100, 0, 0);
    single(201, 0, 1);

    // R6 free run
    for (int i = 0; i < NCH; i++) val[i] = 150;
    wr(4, 32'hA5);
    wr(0, 32'h48);
    base = req_cnt;
    wr(0, 32'h07);
    for (int k = 0; k < 2000 && req_cnt - base < 9; k++) @(negedge clk);
    chk(32'(req_cnt - base), 9, "R6 restart");
    rd_chk(0, 32'hFF, 32'h8F, "R6 scan flag free run");

    // R9 clear storm with events
    val[0] = 50; val[5] = 300;
    @(negedge clk); we = 1'b1; addr = 0; wdata = 32'h6F;
    repeat (60) @(negedge clk);
    we = 1'b0;
    repeat (10) @(negedge clk);
    chk(32'(m_sf & m_cf), 1, "R9 events after clears");

    // R7 free-run stop
    wr(0, 32'h26);
    rd_chk(0, 32'h81, 0, "R7 stopped");
    base = req_cnt;
    repeat (10) @(negedge clk);
    chk(32'(req_cnt - base), 0, "R7 no further requests");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule